// File: doc/BRIEF.md
# Bus Request Grant Arbiter

This block decides who drives a shared external bus: the chip's internal bus master, or one external master that asks for the bus. The external side uses three active-low lines. It asks on a request line. The block answers on a grant line. The external master confirms that it has taken the bus on an acknowledge line. The request and acknowledge lines arrive with no fixed timing relation to the block's clock, so each one first passes through a synchroniser chain.

The internal master reports two conditions on level inputs: that an operand transfer is partly done, and that a locked read-modify-write sequence is running. While either one is high, no grant is given. This keeps a multi-cycle operand in one piece and keeps a locked sequence from being split.

Once the acknowledge is seen, the block drops the grant and raises a release output. That output tells the internal master to stay off the bus until the external master hands it back. Both outputs leave flip-flops, so they carry no combinational path from any input.

Top module: `busarb_top`

## Requirements
- R1: After reset, grantPinN is 1 (grant not given) and releaseBus is 0, so the internal master owns the bus.
- R2: The block is idle, with no transfer or lock active, and the grant line has been high long enough. If reqPinN falls before rising edge k, grantPinN goes low after edge k+SYNC_STAGES and not sooner. With the default SYNC_STAGES = 2, that is the third edge after the fall.
- R3: While xferBusy is 1, an idle arbiter gives no grant even though a request is seen. The grant follows on the first edge at which xferBusy was sampled 0.
- R4: While rmwLock is 1, an idle arbiter gives no grant. The grant follows on the first edge at which rmwLock was sampled 0.
- R5: The grant is given and ackPinN falls before edge k. Then grantPinN returns high and releaseBus rises, both after edge k+SYNC_STAGES. If a withdrawn request and a new acknowledge are first seen in the same cycle, the acknowledge wins.
- R6: releaseBus stays 1 for as long as the synchronised acknowledge is low, even if the request is withdrawn.
- R7: The acknowledge rises before edge k and no request is pending. Then releaseBus falls after edge k+SYNC_STAGES, and the internal master owns the bus again.
- R8: The request is withdrawn before any acknowledge, with reqPinN rising before edge k. Then grantPinN returns high after edge k+SYNC_STAGES, and releaseBus stays 0.
- R9: Each period in which grantPinN is high lasts at least MIN_NEG clock cycles (default 2) before the grant is given again.
- R10: The acknowledge rises while the request is still held low. The grant is then given again without releaseBus falling in between. rmwLock and xferBusy are not consulted in this case, because the internal master is off the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqPinN | input | 1 | Asynchronous bus request from the external master, active low |
| ackPinN | input | 1 | Asynchronous grant acknowledge from the external master, active low |
| xferBusy | input | 1 | Internal master is partway through an operand transfer |
| rmwLock | input | 1 | Internal master is in a locked read-modify-write sequence |
| grantPinN | output | 1 | Bus grant to the external master, active low, registered |
| releaseBus | output | 1 | Tells the internal master to stay off the bus, registered |

## Verification
Two events can come out of the synchronisers in the same cycle while the grant is given: the request is withdrawn and the acknowledge arrives. The bench provokes this by moving reqPinN high and ackPinN low on the same clock. It judges the result by whether releaseBus rises (the acknowledge wins) or the arbiter falls back to idle.

A second collision is also provoked. A one-cycle gap in the request makes the grant fall, and the request then returns at once, so a new grant would fall inside the minimum high time of grantPinN. The bench checks that this grant waits out the full MIN_NEG cycles. In every scenario, a behavioural reference model predicts both outputs, and they are compared on each clock.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRANT = 2'd1,
    ST_EXT   = 2'd2
  } arbState_t;

  typedef struct packed {
    logic setGrant;
    logic clrGrant;
    logic setRel;
    logic clrRel;
  } arbStrobe_t;

endpackage

// File: rtl/busarb_sync.sv
module busarb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinN,
  output logic seen
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= pinN;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= {chain[STAGES-2:0], pinN};
      end
    end
  endgenerate

  assign seen = ~chain[STAGES-1];

endmodule

// File: rtl/busarb_datapath.sv
module busarb_datapath
  import busarb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_NEG     = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqPinN,
  input  logic       ackPinN,
  input  arbStrobe_t strobe,
  output logic       reqSeen,
  output logic       ackSeen,
  output logic       negReady,
  output logic       grantQ,
  output logic       relQ
);

  localparam int NEG_W = $clog2(MIN_NEG + 1);
  localparam logic [NEG_W-1:0] NEG_CAP   = NEG_W'(MIN_NEG);
  localparam logic [NEG_W-1:0] NEG_READY = NEG_W'(MIN_NEG - 1);

  logic [NEG_W-1:0] negCnt;

  busarb_sync #(.STAGES(SYNC_STAGES)) i_reqSync (
    .clk (clk),
    .rstN(rstN),
    .pinN(reqPinN),
    .seen(reqSeen)
  );

  busarb_sync #(.STAGES(SYNC_STAGES)) i_ackSync (
    .clk (clk),
    .rstN(rstN),
    .pinN(ackPinN),
    .seen(ackSeen)
  );

  // Cycles since the grant went inactive, saturating at MIN_NEG
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      negCnt <= '0;
    end else if (strobe.setGrant) begin
      negCnt <= '0;
    end else if (!grantQ && negCnt != NEG_CAP) begin
      negCnt <= negCnt + 1'b1;
    end
  end

  assign negReady = (negCnt >= NEG_READY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantQ <= 1'b0;
      relQ   <= 1'b0;
    end else begin
      if (strobe.setGrant)      grantQ <= 1'b1;
      else if (strobe.clrGrant) grantQ <= 1'b0;
      if (strobe.setRel)        relQ   <= 1'b1;
      else if (strobe.clrRel)   relQ   <= 1'b0;
    end
  end

  // R9: a new grant follows at least two sampled cycles of inactive grant
  p_min_neg_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantQ) |-> !$past(grantQ, 2));

  // R5: a seen acknowledge removes the grant on the next edge
  p_ack_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (grantQ && ackSeen) |=> !grantQ);

  // R6: release holds while the acknowledge is held
  p_rel_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (relQ && ackSeen) |=> relQ);

endmodule

// File: rtl/busarb_ctrl.sv
module busarb_ctrl
  import busarb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqSeen,
  input  logic       ackSeen,
  input  logic       negReady,
  input  logic       xferBusy,
  input  logic       rmwLock,
  output arbStrobe_t strobe
);

  arbState_t state;
  arbState_t nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqSeen && !xferBusy && !rmwLock && negReady) begin
          nextState       = ST_GRANT;
          strobe.setGrant = 1'b1;
        end
      end
      ST_GRANT: begin
        if (ackSeen) begin
          nextState       = ST_EXT;
          strobe.clrGrant = 1'b1;
          strobe.setRel   = 1'b1;
        end else if (!reqSeen) begin
          nextState       = ST_IDLE;
          strobe.clrGrant = 1'b1;
          strobe.clrRel   = 1'b1;
        end
      end
      ST_EXT: begin
        if (!ackSeen) begin
          if (!reqSeen) begin
            nextState     = ST_IDLE;
            strobe.clrRel = 1'b1;
          end else if (negReady) begin
            nextState       = ST_GRANT;
            strobe.setGrant = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R2: a grant is only entered on a seen request
  p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_GRANT) |-> $past(reqSeen));

  // R3: no grant from idle during an operand transfer
  p_no_grant_xfer_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(state == ST_GRANT) && $past(state == ST_IDLE)) |-> $past(!xferBusy));

  // R4: no grant from idle during a locked sequence
  p_no_grant_lock_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(state == ST_GRANT) && $past(state == ST_IDLE)) |-> $past(!rmwLock));

endmodule

// File: rtl/busarb_top.sv
module busarb_top
  import busarb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_NEG     = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqPinN,
  input  logic ackPinN,
  input  logic xferBusy,
  input  logic rmwLock,
  output logic grantPinN,
  output logic releaseBus
);

  arbStrobe_t strobe;
  logic reqSeen;
  logic ackSeen;
  logic negReady;
  logic grantQ;
  logic relQ;

  busarb_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_NEG    (MIN_NEG)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .reqPinN (reqPinN),
    .ackPinN (ackPinN),
    .strobe  (strobe),
    .reqSeen (reqSeen),
    .ackSeen (ackSeen),
    .negReady(negReady),
    .grantQ  (grantQ),
    .relQ    (relQ)
  );

  busarb_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqSeen (reqSeen),
    .ackSeen (ackSeen),
    .negReady(negReady),
    .xferBusy(xferBusy),
    .rmwLock (rmwLock),
    .strobe  (strobe)
  );

  assign grantPinN  = ~grantQ;
  assign releaseBus = relQ;

endmodule

// File: tb/test_busarb_top.sv
module test_busarb_top;

  localparam int SYNC   = 2;
  localparam int MINNEG = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqPinN = 1'b1;
  logic ackPinN = 1'b1;
  logic xferBusy = 1'b0;
  logic rmwLock = 1'b0;
  logic grantPinN;
  logic releaseBus;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";
  bit compareOn = 1'b0;

  always #5 clk = ~clk;

  busarb_top #(.SYNC_STAGES(SYNC), .MIN_NEG(MINNEG)) i_busarb_top (
    .clk       (clk),
    .rstN      (rstN),
    .reqPinN   (reqPinN),
    .ackPinN   (ackPinN),
    .xferBusy  (xferBusy),
    .rmwLock   (rmwLock),
    .grantPinN (grantPinN),
    .releaseBus(releaseBus)
  );

  // Behavioural reference: delay queues for the synchronisers, mode integer
  bit rq[$];
  bit aq[$];
  int mode = 0;          // 0 internal owns, 1 grant given, 2 external owns
  bit mGrant = 0;
  bit mRel = 0;
  int lowTime = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      rq = {};
      aq = {};
      for (int i = 0; i < SYNC; i++) begin
        rq.push_back(1'b0);
        aq.push_back(1'b0);
      end
      mode = 0; mGrant = 0; mRel = 0; lowTime = 0;
    end else begin
      bit sr, sa, oldGrant, setG;
      sr = rq[rq.size()-1];
      sa = aq[aq.size()-1];
      rq.push_front(!reqPinN); void'(rq.pop_back());
      aq.push_front(!ackPinN); void'(aq.pop_back());
      oldGrant = mGrant;
      setG = 1'b0;
      if (mode == 0) begin
        if (sr && !xferBusy && !rmwLock && lowTime >= MINNEG - 1) begin
          mode = 1; mGrant = 1; setG = 1;
        end
      end else if (mode == 1) begin
        if (sa) begin
          mode = 2; mGrant = 0; mRel = 1;
        end else if (!sr) begin
          mode = 0; mGrant = 0; mRel = 0;
        end
      end else begin
        if (!sa) begin
          if (!sr) begin
            mode = 0; mRel = 0;
          end else if (lowTime >= MINNEG - 1) begin
            mode = 1; mGrant = 1; setG = 1;
          end
        end
      end
      if (setG) lowTime = 0;
      else if (!oldGrant && lowTime < MINNEG) lowTime++;
    end
  end

  task automatic check(input bit actual, input bit expected, input string what);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b", tag, what, cycles, actual, expected);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (compareOn) begin
      check(!grantPinN, mGrant, "grant");
      check(releaseBus, mRel, "release");
    end
  end

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    waitCycles(4);
    tag = "R1";
    check(grantPinN, 1'b1, "reset grantPinN");
    check(releaseBus, 1'b0, "reset releaseBus");
    rstN = 1'b1;
    compareOn = 1'b1;
    waitCycles(3);

    // R2 request latency, then R5 ack, R6 hold, R7 return
    tag = "R2"; reqPinN = 1'b0; waitCycles(6);
    tag = "R5"; ackPinN = 1'b0; waitCycles(5);
    tag = "R6"; reqPinN = 1'b1; waitCycles(5);
    tag = "R7"; ackPinN = 1'b1; waitCycles(6);

    // R3 transfer in progress holds off grant
    tag = "R3"; xferBusy = 1'b1; reqPinN = 1'b0; waitCycles(8);
    xferBusy = 1'b0; waitCycles(4);
    ackPinN = 1'b0; waitCycles(4);
    reqPinN = 1'b1; ackPinN = 1'b1; waitCycles(6);

    // R4 locked sequence holds off grant, then R8 withdrawal
    tag = "R4"; rmwLock = 1'b1; reqPinN = 1'b0; waitCycles(8);
    rmwLock = 1'b0; waitCycles(4);
    tag = "R8"; reqPinN = 1'b1; waitCycles(6);

    // R9 one-cycle request gap forces the minimum inactive time
    tag = "R9"; reqPinN = 1'b0; waitCycles(5);
    reqPinN = 1'b1; waitCycles(1);
    reqPinN = 1'b0; waitCycles(6);
    reqPinN = 1'b1; waitCycles(6);

    // R10 ack released while request held, lock raised but ignored
    tag = "R10"; reqPinN = 1'b0; waitCycles(5);
    ackPinN = 1'b0; waitCycles(5);
    rmwLock = 1'b1; ackPinN = 1'b1; waitCycles(6);
    ackPinN = 1'b0; waitCycles(4);
    rmwLock = 1'b0; reqPinN = 1'b1; waitCycles(2);
    ackPinN = 1'b1; waitCycles(6);

    // R5 withdrawal and acknowledge seen in the same cycle
    tag = "R5"; reqPinN = 1'b0; waitCycles(5);
    reqPinN = 1'b1; ackPinN = 1'b0; waitCycles(5);
    ackPinN = 1'b1; waitCycles(6);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    waitCycles(5000);
    checks++;
    errors++;
    $display("FAIL watchdog expired at cycle %0d: actual=running expected=done", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule